// File: doc/BRIEF.md
# Store Function Unit Sequencer

This block steps a store-type function unit through its life in the scoreboard. An accepted issue records the opcode, marks the unit busy and asks for operand reads. Three grants then arrive in fixed order: read, address, write. Each grant freezes the register that was being filled and opens the next one. Each grant also moves the single outstanding request one step along, so the scoreboard always sees one request from this unit and never more.

While the read window is open, the operand registers follow the operand inputs. The read grant freezes them and also stores the memory address, formed as the first operand (base) plus the second (offset), with wrap-around at the data width. While the write window is open, the result register follows the store data input. The write grant freezes it and frees the unit. A grant that does not match the current phase changes nothing and is reported on a one-cycle error pulse. An issue while busy is dropped without a report. Memory access and arbitration between units are handled elsewhere.

Parameter `TRACK_OPEN` selects how a window fills. With 1 (the default) the register loads on every cycle of its window. With 0 it loads only in the grant cycle. Both settings end with the same frozen value.

Top module: `store_fu_seq`

## Requirements
- R1: After reset is released, busy, all three requests and grant_err are 0, and opcode, operands, address and result read 0.
- R2: An issue seen at a clock edge while busy is 0 loads the opcode input into opcode_q and, after that edge, sets busy and req_read to 1.
- R3: While req_read is 1, opa_q and opb_q load rd_a and rd_b at every edge. The edge where go_read is seen freezes them at that edge's inputs and raises req_addr.
- R4: A go_addr seen while req_addr is 1 raises req_write after that edge. While req_write is 1, result_q loads wr_data at every edge.
- R5: A go_write seen while req_write is 1 freezes result_q at that edge's wr_data and clears busy and req_write. The unit then accepts a new issue.
- R6: At most one of req_read, req_addr and req_write is 1 in any cycle. A request is 0 in the cycle after the edge at which its grant is accepted.
- R7: A grant whose request is 0 (go_read without req_read, go_addr without req_addr, go_write without req_write) changes no state and makes grant_err 1 for exactly the next cycle. grant_err is 0 in the cycle after an edge with no such grant.
- R8: An issue seen while busy is 1 is ignored: opcode_q, the phase and the requests are unchanged, and grant_err is not raised.
- R9: At the accepted go_read edge, addr_q loads (rd_a + rd_b) modulo 2^DATA_W, and it holds that value until the next accepted go_read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Issue strobe from the scoreboard |
| issue_op | input | OP_W | Opcode presented with issue |
| go_read | input | 1 | Operand-read grant |
| rd_a | input | DATA_W | First operand (address base) |
| rd_b | input | DATA_W | Second operand (address offset) |
| go_addr | input | 1 | Address grant |
| go_write | input | 1 | Write grant |
| wr_data | input | DATA_W | Store data captured as the result |
| busy | output | 1 | Unit holds an instruction |
| req_read | output | 1 | Requests an operand-read grant |
| req_addr | output | 1 | Requests an address grant |
| req_write | output | 1 | Requests a write grant |
| grant_err | output | 1 | Pulse: previous edge saw a grant out of phase |
| opcode_q | output | OP_W | Captured opcode |
| opa_q | output | DATA_W | Captured first operand |
| opb_q | output | DATA_W | Captured second operand |
| addr_q | output | DATA_W | Computed store address |
| result_q | output | DATA_W | Captured store data |

## Verification
A wrong phase shows up one cycle after the edge that caused it. It appears as a request on the wrong line, two requests at once, or busy that does not match the requests. A register that loads outside its window, or stays open past its grant, shows a value that differs from the frozen grant-cycle input in the next cycle. The random stimulus changes rd_a, rd_b and wr_data every cycle, so such a fault is seen at once. A stray grant that leaks into the state moves the request lines on the same next cycle as the missing grant_err pulse.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_READ = 2'd1,
      PH_ADDR = 2'd2,
      PH_WRITE = 2'd3
   } sfu_phase_e;

   typedef struct packed {
      logic iss;
      logic rd;
      logic ad;
      logic wr;
   } sfu_acc_t;
endpackage

// File: rtl/sfu_phase_ctl.sv
module sfu_phase_ctl
   import sfu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       issue,
   input  logic       go_read,
   input  logic       go_addr,
   input  logic       go_write,
   output sfu_phase_e phase,
   output sfu_acc_t   acc,
   output logic       err_q
);
   sfu_phase_e phase_n;
   logic       stray;

   always_comb begin
      acc.iss = issue    && (phase == PH_IDLE);
      acc.rd  = go_read  && (phase == PH_READ);
      acc.ad  = go_addr  && (phase == PH_ADDR);
      acc.wr  = go_write && (phase == PH_WRITE);
      stray = (go_read  && (phase != PH_READ))
           || (go_addr  && (phase != PH_ADDR))
           || (go_write && (phase != PH_WRITE));
   end

   always_comb begin
      phase_n = phase;
      unique case (phase)
         PH_IDLE:  if (acc.iss) phase_n = PH_READ;
         PH_READ:  if (acc.rd)  phase_n = PH_ADDR;
         PH_ADDR:  if (acc.ad)  phase_n = PH_WRITE;
         PH_WRITE: if (acc.wr)  phase_n = PH_IDLE;
         default:               phase_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         err_q <= 1'b0;
      end else begin
         phase <= phase_n;
         err_q <= stray;
      end
   end
endmodule

// File: rtl/sfu_cap_reg.sv
module sfu_cap_reg #(
   parameter int W     = 16,
   parameter bit TRACK = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         open_i,
   input  logic         grant_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic load;

   generate
      if (TRACK) begin : g_track
         assign load = open_i;
      end else begin : g_grant
         assign load = open_i && grant_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (load) q_o <= d_i;
   end
endmodule

// File: rtl/sfu_addr_gen.sv
module sfu_addr_gen #(
   parameter int W = 16
) (
   input  logic [W-1:0] base_i,
   input  logic [W-1:0] offs_i,
   output logic [W-1:0] sum_o
);
   logic [W:0] full;
   assign full  = {1'b0, base_i} + {1'b0, offs_i};
   assign sum_o = full[W-1:0];
endmodule

// File: rtl/store_fu_seq.sv
module store_fu_seq
   import sfu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int OP_W       = 8,
   parameter bit TRACK_OPEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [OP_W-1:0]   issue_op,
   input  logic              go_read,
   input  logic [DATA_W-1:0] rd_a,
   input  logic [DATA_W-1:0] rd_b,
   input  logic              go_addr,
   input  logic              go_write,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              req_read,
   output logic              req_addr,
   output logic              req_write,
   output logic              grant_err,
   output logic [OP_W-1:0]   opcode_q,
   output logic [DATA_W-1:0] opa_q,
   output logic [DATA_W-1:0] opb_q,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] result_q
);
   initial begin
      if (DATA_W < 1) $error("store_fu_seq: DATA_W must be at least 1");
      if (OP_W < 1)   $error("store_fu_seq: OP_W must be at least 1");
   end

   sfu_phase_e        phase;
   sfu_acc_t          acc;
   logic [DATA_W-1:0] sum;
   logic              in_read, in_write;

   sfu_phase_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .issue(issue),
      .go_read(go_read), .go_addr(go_addr), .go_write(go_write),
      .phase(phase), .acc(acc), .err_q(grant_err)
   );

   assign in_read  = (phase == PH_READ);
   assign in_write = (phase == PH_WRITE);

   // opcode loads only at an accepted issue
   sfu_cap_reg #(.W(OP_W), .TRACK(1'b0)) u_op (
      .clk(clk), .rst_n(rst_n), .open_i(acc.iss), .grant_i(acc.iss),
      .d_i(issue_op), .q_o(opcode_q)
   );

   sfu_cap_reg #(.W(DATA_W), .TRACK(TRACK_OPEN)) u_opa (
      .clk(clk), .rst_n(rst_n), .open_i(in_read), .grant_i(acc.rd),
      .d_i(rd_a), .q_o(opa_q)
   );

   sfu_cap_reg #(.W(DATA_W), .TRACK(TRACK_OPEN)) u_opb (
      .clk(clk), .rst_n(rst_n), .open_i(in_read), .grant_i(acc.rd),
      .d_i(rd_b), .q_o(opb_q)
   );

   sfu_addr_gen #(.W(DATA_W)) u_agen (
      .base_i(rd_a), .offs_i(rd_b), .sum_o(sum)
   );

   // address is fixed at the read grant and held through the address phase
   sfu_cap_reg #(.W(DATA_W), .TRACK(1'b0)) u_addr (
      .clk(clk), .rst_n(rst_n), .open_i(acc.rd), .grant_i(acc.rd),
      .d_i(sum), .q_o(addr_q)
   );

   sfu_cap_reg #(.W(DATA_W), .TRACK(TRACK_OPEN)) u_res (
      .clk(clk), .rst_n(rst_n), .open_i(in_write), .grant_i(acc.wr),
      .d_i(wr_data), .q_o(result_q)
   );

   assign busy      = (phase != PH_IDLE);
   assign req_read  = in_read;
   assign req_addr  = (phase == PH_ADDR);
   assign req_write = in_write;
endmodule

// File: rtl/sfu_chk.sv
module sfu_chk #(
   parameter int DATA_W = 16,
   parameter int OP_W   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue,
   input logic              go_read,
   input logic [DATA_W-1:0] rd_a,
   input logic [DATA_W-1:0] rd_b,
   input logic              go_addr,
   input logic              go_write,
   input logic [DATA_W-1:0] wr_data,
   input logic              busy,
   input logic              req_read,
   input logic              req_addr,
   input logic              req_write,
   input logic              grant_err,
   input logic [OP_W-1:0]   opcode_q,
   input logic [DATA_W-1:0] addr_q,
   input logic [DATA_W-1:0] result_q
);
   logic [DATA_W-1:0] sum_in;
   assign sum_in = rd_a + rd_b;

   p_one_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_read, req_addr, req_write}));

   p_issue_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !busy) |=> (busy && req_read));

   p_read_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_read && go_read) |=> (req_addr && !req_read));

   p_addr_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_read && go_read) |=> (addr_q == $past(sum_in)));

   p_addr_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_addr && go_addr) |=> (req_write && !req_addr));

   p_write_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_write && go_write) |=> (!busy && result_q == $past(wr_data)));

   p_stray_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((go_read && !req_read) || (go_addr && !req_addr) || (go_write && !req_write))
      |=> grant_err);

   p_busy_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && issue) |=> $stable(opcode_q));
endmodule

bind store_fu_seq sfu_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_sfu_chk (
   .clk(clk), .rst_n(rst_n), .issue(issue), .go_read(go_read),
   .rd_a(rd_a), .rd_b(rd_b), .go_addr(go_addr), .go_write(go_write),
   .wr_data(wr_data), .busy(busy), .req_read(req_read), .req_addr(req_addr),
   .req_write(req_write), .grant_err(grant_err), .opcode_q(opcode_q),
   .addr_q(addr_q), .result_q(result_q)
);

// File: tb/tb_store_fu_seq.sv
`timescale 1ns/1ps
module tb_store_fu_seq;
   localparam int DW = 16;
   localparam int OW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue = 1'b0;
   logic [OW-1:0] issue_op = '0;
   logic          go_read = 1'b0, go_addr = 1'b0, go_write = 1'b0;
   logic [DW-1:0] rd_a = '0, rd_b = '0, wr_data = '0;
   logic          busy, req_read, req_addr, req_write, grant_err;
   logic [OW-1:0] opcode_q;
   logic [DW-1:0] opa_q, opb_q, addr_q, result_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model
   int            m_ph  = 0;
   logic          m_err = 1'b0;
   logic [OW-1:0] m_op  = '0;
   logic [DW-1:0] m_a = '0, m_b = '0, m_addr = '0, m_res = '0;

   always #5 clk = ~clk;

   store_fu_seq #(.DATA_W(DW), .OP_W(OW)) dut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .issue_op(issue_op),
      .go_read(go_read), .rd_a(rd_a), .rd_b(rd_b), .go_addr(go_addr),
      .go_write(go_write), .wr_data(wr_data), .busy(busy),
      .req_read(req_read), .req_addr(req_addr), .req_write(req_write),
      .grant_err(grant_err), .opcode_q(opcode_q), .opa_q(opa_q),
      .opb_q(opb_q), .addr_q(addr_q), .result_q(result_q)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] addr_of(input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [DW:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[DW-1:0];
   endfunction

   task automatic compare_all();
      chk("R2/R5 busy",       busy,      m_ph != 0);
      chk("R6 req_read",      req_read,  m_ph == 1);
      chk("R6 req_addr",      req_addr,  m_ph == 2);
      chk("R6 req_write",     req_write, m_ph == 3);
      chk("R7 grant_err",     grant_err, m_err);
      chk("R2/R8 opcode_q",   opcode_q,  m_op);
      chk("R3 opa_q",         opa_q,     m_a);
      chk("R3 opb_q",         opb_q,     m_b);
      chk("R9 addr_q",        addr_q,    m_addr);
      chk("R4/R5 result_q",   result_q,  m_res);
   endtask

   // drive one cycle, advance the model, then check in the next low phase
   task automatic step(input logic iss, input logic [OW-1:0] op,
                       input logic gr, input logic ga, input logic gw,
                       input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [DW-1:0] w);
      int nph;
      issue = iss; issue_op = op; go_read = gr; go_addr = ga; go_write = gw;
      rd_a = a; rd_b = b; wr_data = w;
      nph   = m_ph;
      m_err = (gr && m_ph != 1) || (ga && m_ph != 2) || (gw && m_ph != 3);
      if (m_ph == 0 && iss) begin m_op = op; nph = 1; end
      if (m_ph == 1) begin
         m_a = a; m_b = b;
         if (gr) begin m_addr = addr_of(a, b); nph = 2; end
      end
      if (m_ph == 2 && ga) nph = 3;
      if (m_ph == 3) begin
         m_res = w;
         if (gw) nph = 0;
      end
      m_ph = nph;
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      compare_all();

      // R2 R3 R4 R5 R9: directed pass with address wrap
      step(1, 8'hA5, 0, 0, 0, 16'h1111, 16'h2222, 16'h0);
      step(1, 8'h3C, 0, 0, 0, 16'h1234, 16'h0001, 16'h0);   // R8 issue while busy
      step(0, 8'h00, 1, 0, 0, 16'hFFFF, 16'h0003, 16'h0);   // R9 wraps to 0002
      chk("R9 wrapped address", addr_q, 32'h0002);
      step(0, 8'h00, 1, 0, 0, 16'h5555, 16'h0001, 16'h0);   // R7 stray go_read
      chk("R7 stray read keeps addr", addr_q, 32'h0002);
      step(0, 8'h00, 0, 0, 1, 16'h0, 16'h0, 16'hBEEF);      // R7 stray go_write
      chk("R7 error one cycle", grant_err, 1);
      step(0, 8'h00, 0, 1, 0, 16'h0, 16'h0, 16'h7777);      // R4 address grant
      chk("R7 error clears", grant_err, 0);
      step(0, 8'h00, 0, 0, 0, 16'h0, 16'h0, 16'h4242);      // R4 result tracks
      step(0, 8'h00, 0, 0, 1, 16'h0, 16'h0, 16'hCAFE);      // R5 freeze
      chk("R5 result frozen", result_q, 32'hCAFE);
      step(0, 8'h00, 0, 0, 0, 16'h0, 16'h0, 16'h9999);
      chk("R5 result holds after write", result_q, 32'hCAFE);
      step(1, 8'h77, 0, 0, 0, 16'h0, 16'h0, 16'h0);         // R5 new issue
      chk("R5 reissue opcode", opcode_q, 32'h77);

      // random phase: grants mostly in phase, some stray
      for (int i = 0; i < 4000; i++) begin
         logic ig, rg, ag, wg;
         ig = ($urandom_range(0, 99) < 40);
         rg = (m_ph == 1) ? ($urandom_range(0, 99) < 40) : ($urandom_range(0, 99) < 4);
         ag = (m_ph == 2) ? ($urandom_range(0, 99) < 40) : ($urandom_range(0, 99) < 4);
         wg = (m_ph == 3) ? ($urandom_range(0, 99) < 40) : ($urandom_range(0, 99) < 4);
         step(ig, OW'($urandom), rg, ag, wg, DW'($urandom), DW'($urandom), DW'($urandom));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule